// File: doc/BRIEF.md
# Audio ADC power-mode sequencer

This block is a host-side controller that steps an external multichannel audio converter through its three power conditions: hardware-off, low-power sleep and active capture. It owns the converter's active-low power-down pin. It gates the frame-sync and bit-clock outputs. It issues register writes and reads through a generic request/acknowledge register-access port that carries page, address and data. A parameterized millisecond timer, derived from the system clock frequency, enforces every mandatory wait.

Software, or a higher-level controller, gives three single-cycle commands: record, sleep and shutdown. It also gives a supplies-good level. The block answers with a mode code and an error flag. On the first wake after power-up it programs channel and block power settings. On later wakes it relies on the retained register contents and only clears the sleep bit. Before it stops the clocks on the way to sleep, it polls the converter's status register.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset, and for as long as suppliesOk stays low, pwrDownN is 0, fsyncEn and bclkEn are 0, busReq is 0 and mode is 0 (off).
- R2: In the cycle after suppliesOk is seen high, pwrDownN goes to 1 and mode becomes 1 (boot). Mode stays 1 for at least POR_MS*CLK_KHZ cycles with no bus request, then becomes 2 (sleep).
- R3: A record command in mode 2 issues a write of WAKE_VAL (default 0x00) to page 0 address 2. No further bus request follows for at least WAKE_MS*CLK_KHZ cycles after its acknowledge. Every request uses page 0.
- R4: On the first wake after power-up, three writes follow the wait, in this order: IN_CH_EN to address 115, OUT_CH_EN to address 116, then PWR_CFG to address 117.
- R5: fsyncEn and bclkEn are always equal. They rise only after the last wake write is acknowledged, and mode 4 (active) always has them at 1. They are never 1 in mode 2 or mode 3 (waking).
- R6: A sleep command in mode 4 writes SLEEP_VAL (default 0x01) to page 0 address 2. After its acknowledge, no request follows for at least SLEEP_MS*CLK_KHZ cycles, and then address 119 is read.
- R7: If bit 7 of the status read data is 1, the clocks are switched off and mode becomes 2.
- R8: A wake after the first (register contents retained) issues only the address 2 write, waits, then enables the clocks and enters mode 4.
- R9: If bit 7 of the status read is 0, the status register is read again, after a one-cycle gap, up to MAX_RETRY further times. A later read with bit 7 set completes the sleep entry as in R7 with seqError at 0.
- R10: If all 1+MAX_RETRY status reads return bit 7 at 0, seqError goes to 1. Mode stays 5 (entering sleep), the clocks stay on and no further request is issued.
- R11: A request holds busReq, busWrite, busPage, busAddr and busWdata steady until busAck. One transaction is outstanding at a time.
- R12: A shutdown command in any state gives, in the next cycle, pwrDownN 0, clocks off, busReq 0, seqError 0 and mode 0. The following power-up repeats R2, and its first wake repeats the R4 writes.
- R13: A sleep command received while mode is 3 is held. Once mode 4 is reached with the clocks on, the sleep sequence of R6 runs without a new command.
- R14: A record command outside mode 2 and a sleep command in mode 2 are ignored: no request is issued and the mode does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| suppliesOk | input | 1 | Converter supplies have settled |
| cmdRecord | input | 1 | Single-cycle request to enter active capture |
| cmdSleep | input | 1 | Single-cycle request to enter sleep |
| cmdShutdown | input | 1 | Single-cycle request to force hardware-off |
| busReq | output | 1 | Register-access request, held until acknowledge |
| busWrite | output | 1 | 1 = write, 0 = read |
| busPage | output | 8 | Register page |
| busAddr | output | 8 | Register address |
| busWdata | output | 8 | Write data |
| busAck | input | 1 | Single-cycle transaction completion |
| busRdata | input | 8 | Read data, valid with busAck |
| pwrDownN | output | 1 | Active-low converter power-down pin |
| fsyncEn | output | 1 | Frame-sync output gate |
| bclkEn | output | 1 | Bit-clock output gate |
| mode | output | 3 | 0 off, 1 boot, 2 sleep, 3 waking, 4 active, 5 entering sleep |
| seqError | output | 1 | Status poll exhausted its retries |

## Verification
Two pairs of events can fall into the same cycle. A sleep command can arrive while the wake sequence is still running, and a shutdown command can take priority over whatever step the controller is on. The bench pulses sleep a few cycles into a wake. It then expects a scoreboard order of wake write, sleep write after the wake wait, and status read, and it counts exactly one rising edge of the clock gate in between. For shutdown, the pin, the clocks, the error flag and the request are judged one cycle after the command, taken from an error-stalled state. The next power-up must then replay the full set of configuration writes.

// File: rtl/adc_pwr_seq_pkg.sv
package adc_pwr_seq_pkg;

  localparam int REG_W = 8;

  localparam logic [REG_W-1:0] PAGE_MAIN      = 8'd0;
  localparam logic [REG_W-1:0] REG_POWER_MODE = 8'd2;
  localparam logic [REG_W-1:0] REG_IN_CH      = 8'd115;
  localparam logic [REG_W-1:0] REG_OUT_CH     = 8'd116;
  localparam logic [REG_W-1:0] REG_BLOCK_PWR  = 8'd117;
  localparam logic [REG_W-1:0] REG_DEV_STATUS = 8'd119;

  typedef enum logic [2:0] {
    MODE_OFF      = 3'd0,
    MODE_BOOT     = 3'd1,
    MODE_SLEEP    = 3'd2,
    MODE_WAKING   = 3'd3,
    MODE_ACTIVE   = 3'd4,
    MODE_SLEEPING = 3'd5
  } seqMode_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_WAKE, OP_CH_IN, OP_CH_OUT, OP_POWER, OP_SLEEP, OP_STATUS
  } busOp_e;

  typedef enum logic [1:0] {
    WAIT_POR, WAIT_WAKE, WAIT_SLEEP
  } waitSel_e;

  typedef struct packed {
    logic     timerLoad;
    waitSel_e waitSel;
    logic     retryClr;
    logic     retryInc;
    logic     pinRelease;
    logic     pinHold;
    logic     clkOn;
    logic     clkOff;
    logic     errSet;
    logic     errClr;
    busOp_e   busOp;
  } seqStrobe_t;

endpackage

// File: rtl/adc_pwr_seq_ctrl.sv
module adc_pwr_seq_ctrl
  import adc_pwr_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       suppliesOk,
  input  logic       cmdRecord,
  input  logic       cmdSleep,
  input  logic       cmdShutdown,
  input  logic       busAck,
  input  logic       timerDone,
  input  logic       retryExhausted,
  input  logic       statusBit,
  output seqStrobe_t strobe,
  output seqMode_e   mode
);

  typedef enum logic [3:0] {
    ST_OFF, ST_BOOT, ST_SLEEP,
    ST_WR_WAKE, ST_WAIT_WAKE, ST_WR_IN, ST_WR_OUT, ST_WR_PWR, ST_CLK_ON,
    ST_ACTIVE,
    ST_WR_SLEEP, ST_WAIT_SLEEP, ST_RD_STAT, ST_RD_GAP, ST_STUCK
  } ctrlState_e;

  ctrlState_e state, stateNext;
  logic       needCfg;
  logic       pendSleep;
  logic       inWake;

  assign inWake = (state == ST_WR_WAKE) || (state == ST_WAIT_WAKE) ||
                  (state == ST_WR_IN)   || (state == ST_WR_OUT)    ||
                  (state == ST_WR_PWR)  || (state == ST_CLK_ON);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (cmdShutdown) begin
      stateNext      = ST_OFF;
      strobe.pinHold = 1'b1;
      strobe.clkOff  = 1'b1;
      strobe.errClr  = 1'b1;
    end else begin
      unique case (state)
        ST_OFF: if (suppliesOk) begin
          strobe.pinRelease = 1'b1;
          strobe.timerLoad  = 1'b1;
          strobe.waitSel    = WAIT_POR;
          stateNext         = ST_BOOT;
        end
        ST_BOOT: if (timerDone) stateNext = ST_SLEEP;
        ST_SLEEP: if (cmdRecord) stateNext = ST_WR_WAKE;
        ST_WR_WAKE: begin
          strobe.busOp = OP_WAKE;
          if (busAck) begin
            strobe.timerLoad = 1'b1;
            strobe.waitSel   = WAIT_WAKE;
            stateNext        = ST_WAIT_WAKE;
          end
        end
        ST_WAIT_WAKE: if (timerDone) stateNext = needCfg ? ST_WR_IN : ST_CLK_ON;
        ST_WR_IN: begin
          strobe.busOp = OP_CH_IN;
          if (busAck) stateNext = ST_WR_OUT;
        end
        ST_WR_OUT: begin
          strobe.busOp = OP_CH_OUT;
          if (busAck) stateNext = ST_WR_PWR;
        end
        ST_WR_PWR: begin
          strobe.busOp = OP_POWER;
          if (busAck) stateNext = ST_CLK_ON;
        end
        ST_CLK_ON: begin
          strobe.clkOn = 1'b1;
          stateNext    = ST_ACTIVE;
        end
        ST_ACTIVE: if (cmdSleep || pendSleep) stateNext = ST_WR_SLEEP;
        ST_WR_SLEEP: begin
          strobe.busOp = OP_SLEEP;
          if (busAck) begin
            strobe.timerLoad = 1'b1;
            strobe.waitSel   = WAIT_SLEEP;
            stateNext        = ST_WAIT_SLEEP;
          end
        end
        ST_WAIT_SLEEP: if (timerDone) begin
          strobe.retryClr = 1'b1;
          stateNext       = ST_RD_STAT;
        end
        ST_RD_STAT: begin
          strobe.busOp = OP_STATUS;
          if (busAck) begin
            if (statusBit) begin
              strobe.clkOff = 1'b1;
              stateNext     = ST_SLEEP;
            end else if (retryExhausted) begin
              strobe.errSet = 1'b1;
              stateNext     = ST_STUCK;
            end else begin
              strobe.retryInc = 1'b1;
              stateNext       = ST_RD_GAP;
            end
          end
        end
        ST_RD_GAP: stateNext = ST_RD_STAT;
        ST_STUCK:  stateNext = ST_STUCK;
        default:   stateNext = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_OFF;
      needCfg   <= 1'b1;
      pendSleep <= 1'b0;
    end else begin
      state <= stateNext;
      if (cmdShutdown) begin
        needCfg   <= 1'b1;
        pendSleep <= 1'b0;
      end else begin
        if (state == ST_WR_PWR && busAck) needCfg <= 1'b0;
        if (inWake && cmdSleep) pendSleep <= 1'b1;
        else if (state == ST_ACTIVE) pendSleep <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (state)
      ST_OFF:    mode = MODE_OFF;
      ST_BOOT:   mode = MODE_BOOT;
      ST_SLEEP:  mode = MODE_SLEEP;
      ST_ACTIVE: mode = MODE_ACTIVE;
      ST_WR_SLEEP, ST_WAIT_SLEEP, ST_RD_STAT, ST_RD_GAP, ST_STUCK:
                 mode = MODE_SLEEPING;
      default:   mode = MODE_WAKING;
    endcase
  end

endmodule

// File: rtl/adc_pwr_seq_dp.sv
module adc_pwr_seq_dp
  import adc_pwr_seq_pkg::*;
#(
  parameter int               CLK_KHZ    = 100000,
  parameter int               POR_MS     = 1,
  parameter int               WAKE_MS    = 1,
  parameter int               SLEEP_MS   = 6,
  parameter int               MAX_RETRY  = 3,
  parameter int               STATUS_BIT = 7,
  parameter logic [REG_W-1:0] IN_CH_EN   = 8'hF0,
  parameter logic [REG_W-1:0] OUT_CH_EN  = 8'hF0,
  parameter logic [REG_W-1:0] PWR_CFG    = 8'hE0,
  parameter logic [REG_W-1:0] WAKE_VAL   = 8'h00,
  parameter logic [REG_W-1:0] SLEEP_VAL  = 8'h01
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [REG_W-1:0] busRdata,
  output logic             timerDone,
  output logic             retryExhausted,
  output logic             statusBit,
  output logic             busReq,
  output logic             busWrite,
  output logic [REG_W-1:0] busPage,
  output logic [REG_W-1:0] busAddr,
  output logic [REG_W-1:0] busWdata,
  output logic             pwrDownN,
  output logic             fsyncEn,
  output logic             bclkEn,
  output logic             seqError
);

  localparam int POR_CYC   = POR_MS * CLK_KHZ;
  localparam int WAKE_CYC  = WAKE_MS * CLK_KHZ;
  localparam int SLEEP_CYC = SLEEP_MS * CLK_KHZ;
  localparam int MAX_A     = (POR_CYC > WAKE_CYC) ? POR_CYC : WAKE_CYC;
  localparam int MAX_CYC   = (MAX_A > SLEEP_CYC) ? MAX_A : SLEEP_CYC;
  localparam int CNT_W     = $clog2(MAX_CYC + 1);
  localparam int RETRY_W   = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;

  // wait timer: loaded with the cycle count, done once it has run down
  logic [CNT_W-1:0] waitCnt;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    unique case (strobe.waitSel)
      WAIT_POR:   loadVal = CNT_W'(POR_CYC);
      WAIT_WAKE:  loadVal = CNT_W'(WAKE_CYC);
      default:    loadVal = CNT_W'(SLEEP_CYC);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  waitCnt <= '0;
    else if (strobe.timerLoad)  waitCnt <= loadVal;
    else if (waitCnt != '0)     waitCnt <= waitCnt - 1'b1;
  end

  assign timerDone = (waitCnt == '0);

  // status poll retry counter
  generate
    if (MAX_RETRY > 0) begin : g_retry
      logic [RETRY_W-1:0] retryCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                retryCnt <= '0;
        else if (strobe.retryClr) retryCnt <= '0;
        else if (strobe.retryInc) retryCnt <= retryCnt + 1'b1;
      end
      assign retryExhausted = (retryCnt == RETRY_W'(MAX_RETRY));
    end else begin : g_noRetry
      assign retryExhausted = 1'b1;
    end
  endgenerate

  logic unusedRdata;
  assign unusedRdata = ^busRdata;
  assign statusBit   = busRdata[STATUS_BIT];

  // register access decode
  always_comb begin
    busReq   = (strobe.busOp != OP_NONE);
    busWrite = 1'b1;
    busPage  = PAGE_MAIN;
    busAddr  = REG_POWER_MODE;
    busWdata = '0;
    unique case (strobe.busOp)
      OP_WAKE:   busWdata = WAKE_VAL;
      OP_SLEEP:  busWdata = SLEEP_VAL;
      OP_CH_IN:  begin busAddr = REG_IN_CH;     busWdata = IN_CH_EN;  end
      OP_CH_OUT: begin busAddr = REG_OUT_CH;    busWdata = OUT_CH_EN; end
      OP_POWER:  begin busAddr = REG_BLOCK_PWR; busWdata = PWR_CFG;   end
      OP_STATUS: begin busAddr = REG_DEV_STATUS; busWrite = 1'b0;     end
      default:   busWrite = 1'b0;
    endcase
  end

  // pin, clock gate and error registers
  logic clkGate;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrDownN <= 1'b0;
      clkGate  <= 1'b0;
      seqError <= 1'b0;
    end else begin
      if (strobe.pinHold)         pwrDownN <= 1'b0;
      else if (strobe.pinRelease) pwrDownN <= 1'b1;
      if (strobe.clkOff)          clkGate  <= 1'b0;
      else if (strobe.clkOn)      clkGate  <= 1'b1;
      if (strobe.errClr)          seqError <= 1'b0;
      else if (strobe.errSet)     seqError <= 1'b1;
    end
  end

  assign fsyncEn = clkGate;
  assign bclkEn  = clkGate;

endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_seq_pkg::*;
#(
  parameter int         CLK_KHZ    = 100000,
  parameter int         POR_MS     = 1,
  parameter int         WAKE_MS    = 1,
  parameter int         SLEEP_MS   = 6,
  parameter int         MAX_RETRY  = 3,
  parameter int         STATUS_BIT = 7,
  parameter logic [7:0] IN_CH_EN   = 8'hF0,
  parameter logic [7:0] OUT_CH_EN  = 8'hF0,
  parameter logic [7:0] PWR_CFG    = 8'hE0,
  parameter logic [7:0] WAKE_VAL   = 8'h00,
  parameter logic [7:0] SLEEP_VAL  = 8'h01
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       suppliesOk,
  input  logic       cmdRecord,
  input  logic       cmdSleep,
  input  logic       cmdShutdown,
  output logic       busReq,
  output logic       busWrite,
  output logic [7:0] busPage,
  output logic [7:0] busAddr,
  output logic [7:0] busWdata,
  input  logic       busAck,
  input  logic [7:0] busRdata,
  output logic       pwrDownN,
  output logic       fsyncEn,
  output logic       bclkEn,
  output logic [2:0] mode,
  output logic       seqError
);

  seqStrobe_t strobe;
  seqMode_e   modeInt;
  logic       timerDone, retryExhausted, statusBit;

  adc_pwr_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .suppliesOk(suppliesOk),
    .cmdRecord(cmdRecord), .cmdSleep(cmdSleep), .cmdShutdown(cmdShutdown),
    .busAck(busAck), .timerDone(timerDone), .retryExhausted(retryExhausted),
    .statusBit(statusBit), .strobe(strobe), .mode(modeInt)
  );

  adc_pwr_seq_dp #(
    .CLK_KHZ(CLK_KHZ), .POR_MS(POR_MS), .WAKE_MS(WAKE_MS), .SLEEP_MS(SLEEP_MS),
    .MAX_RETRY(MAX_RETRY), .STATUS_BIT(STATUS_BIT), .IN_CH_EN(IN_CH_EN),
    .OUT_CH_EN(OUT_CH_EN), .PWR_CFG(PWR_CFG), .WAKE_VAL(WAKE_VAL),
    .SLEEP_VAL(SLEEP_VAL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busRdata(busRdata),
    .timerDone(timerDone), .retryExhausted(retryExhausted), .statusBit(statusBit),
    .busReq(busReq), .busWrite(busWrite), .busPage(busPage), .busAddr(busAddr),
    .busWdata(busWdata), .pwrDownN(pwrDownN), .fsyncEn(fsyncEn), .bclkEn(bclkEn),
    .seqError(seqError)
  );

  assign mode = modeInt;

endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdShutdown,
  input logic       busReq,
  input logic       busWrite,
  input logic [7:0] busPage,
  input logic [7:0] busAddr,
  input logic [7:0] busWdata,
  input logic       busAck,
  input logic       pwrDownN,
  input logic       fsyncEn,
  input logic       bclkEn,
  input logic [2:0] mode,
  input logic       seqError
);

  AST_NO_REQ_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDownN |-> !busReq); // R1

  AST_PAGE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> busPage == 8'd0); // R3

  AST_CLK_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    fsyncEn == bclkEn); // R5

  AST_ACTIVE_CLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    mode == 3'd4 |-> fsyncEn); // R5

  AST_NO_CLK_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd2 || mode == 3'd3) |-> !fsyncEn); // R5

  AST_ERR_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    seqError |-> (mode == 3'd5 && !busReq && fsyncEn)); // R10

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck && !cmdShutdown) |=>
      (busReq && $stable(busWrite) && $stable(busAddr) && $stable(busWdata))); // R11

  AST_SHDN_PIN: assert property (@(posedge clk) disable iff (!rstN)
    cmdShutdown |=> (!pwrDownN && !fsyncEn && !seqError && mode == 3'd0)); // R12

endmodule

bind adc_pwr_seq adc_pwr_seq_chk u_chk (.*);

// File: tb/adc_pwr_seq_test.sv
`timescale 1ns/1ps
module adc_pwr_seq_test;

  localparam int KHZ      = 10;
  localparam int POR_C    = 1 * KHZ;
  localparam int WAKE_C   = 1 * KHZ;
  localparam int SLEEP_C  = 6 * KHZ;
  localparam int RETRIES  = 2;
  localparam logic [7:0] V_IN = 8'hF0, V_OUT = 8'hF0, V_PWR = 8'hE0;
  localparam logic [7:0] V_WAKE = 8'h00, V_SLP = 8'h01;

  logic clk = 1'b0, rstN = 1'b0;
  logic suppliesOk = 1'b0, cmdRecord = 1'b0, cmdSleep = 1'b0, cmdShutdown = 1'b0;
  logic busReq, busWrite, busAck = 1'b0;
  logic [7:0] busPage, busAddr, busWdata, busRdata = 8'h00;
  logic pwrDownN, fsyncEn, bclkEn, seqError;
  logic [2:0] mode;

  always #2.5 clk = ~clk;

  adc_pwr_seq #(.CLK_KHZ(KHZ), .POR_MS(1), .WAKE_MS(1), .SLEEP_MS(6),
    .MAX_RETRY(RETRIES), .IN_CH_EN(V_IN), .OUT_CH_EN(V_OUT), .PWR_CFG(V_PWR),
    .WAKE_VAL(V_WAKE), .SLEEP_VAL(V_SLP)) uut (.*);

  typedef struct {
    logic       wr;
    logic [7:0] addr;
    logic [7:0] data;
    int         minGap;
    string      tag;
  } busItem_t;

  busItem_t expQ[$];
  int nChecks = 0, nErr = 0, unexpected = 0, clkRises = 0, clkEarly = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic expectBus(input logic wr, input logic [7:0] addr,
                           input logic [7:0] data, input int gap, input string tag);
    busItem_t it;
    it.wr = wr; it.addr = addr; it.data = data; it.minGap = gap; it.tag = tag;
    expQ.push_back(it);
  endtask

  // scoreboard monitor and bus responder
  initial begin : monitor
    int cyc = 0, lastRef = 0, wait2 = 0;
    bit busy = 1'b0;
    logic prevClk = 1'b0, prevPin = 1'b0;
    busItem_t it;
    forever begin
      @(negedge clk);
      cyc++;
      busAck = 1'b0;
      if (fsyncEn && !prevClk) clkRises++;
      if (fsyncEn && (mode == 3'd2 || mode == 3'd3)) clkEarly++;
      if (pwrDownN && !prevPin) lastRef = cyc;
      prevClk = fsyncEn;
      prevPin = pwrDownN;
      if (busy) begin
        if (!busReq) busy = 1'b0;
        else if (wait2 == 0) begin
          busAck = 1'b1;
          busRdata = it.data;
          busy = 1'b0;
          lastRef = cyc;
        end else wait2--;
      end else if (busReq && rstN) begin
        if (expQ.size() == 0) begin
          unexpected++;
          nErr++;
          $display("FAIL R14 unexpected request: actual addr=%0d expected none", busAddr);
        end else begin
          it = expQ.pop_front();
          check(busWrite == it.wr && busPage == 8'd0 && busAddr == it.addr &&
                (!it.wr || busWdata == it.data), {it.tag, " transaction fields"},
                {busWrite, busAddr, busWdata}, {it.wr, it.addr, it.wr ? it.data : busWdata});
          check(cyc - lastRef >= it.minGap, {it.tag, " wait before request"},
                cyc - lastRef, it.minGap);
          busy = 1'b1;
          wait2 = 2;
        end
      end
    end
  end

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) cmdRecord = 1'b1;
    else if (which == 1) cmdSleep = 1'b1;
    else cmdShutdown = 1'b1;
    @(negedge clk);
    cmdRecord = 1'b0; cmdSleep = 1'b0; cmdShutdown = 1'b0;
  endtask

  task automatic waitMode(input logic [2:0] m, input int maxc, input string tag,
                          output int cycles);
    cycles = 0;
    while (mode != m && cycles < maxc) begin
      @(negedge clk);
      cycles++;
    end
    check(mode == m, {tag, " mode reached"}, mode, m);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nErr++; nChecks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin : driver
    int c, rises;
    repeat (3) @(negedge clk);
    check(!pwrDownN && !fsyncEn && !bclkEn && !busReq && mode == 3'd0,
          "R1 reset state", {pwrDownN, fsyncEn, busReq, mode}, 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    check(!pwrDownN && mode == 3'd0, "R1 held off without supplies", pwrDownN, 0);

    // power-up
    suppliesOk = 1'b1;
    @(negedge clk);
    check(pwrDownN && mode == 3'd1, "R2 pin released", {pwrDownN, mode}, {1'b1, 3'd1});
    waitMode(3'd2, 100, "R2", c);
    check(c >= POR_C, "R2 boot wait length", c + 1, POR_C);

    // R14: sleep in sleep ignored
    pulse(1);
    repeat (20) @(negedge clk);
    check(mode == 3'd2 && unexpected == 0, "R14 sleep ignored in sleep", mode, 2);

    // first wake with configuration
    expectBus(1, 8'd2, V_WAKE, 0, "R3");
    expectBus(1, 8'd115, V_IN, WAKE_C, "R4");
    expectBus(1, 8'd116, V_OUT, 0, "R4");
    expectBus(1, 8'd117, V_PWR, 0, "R4");
    pulse(0);
    waitMode(3'd4, 200, "R5", c);
    check(expQ.size() == 0, "R4 all config writes issued", expQ.size(), 0);
    check(fsyncEn && bclkEn && clkEarly == 0, "R5 clocks on after writes",
          {fsyncEn, bclkEn, clkEarly}, 2'b11);

    // R14: record while active ignored
    pulse(0);
    repeat (20) @(negedge clk);
    check(mode == 3'd4 && unexpected == 0, "R14 record ignored when active", mode, 4);

    // sleep entry with good status
    expectBus(1, 8'd2, V_SLP, 0, "R6");
    expectBus(0, 8'd119, 8'h80, SLEEP_C, "R6");
    pulse(1);
    waitMode(3'd2, 300, "R7", c);
    check(!fsyncEn && !bclkEn && expQ.size() == 0, "R7 clocks stopped",
          {fsyncEn, bclkEn}, 0);

    // re-wake: no configuration writes
    expectBus(1, 8'd2, V_WAKE, 0, "R8");
    pulse(0);
    waitMode(3'd4, 200, "R8", c);
    repeat (20) @(negedge clk);
    check(fsyncEn && expQ.size() == 0 && unexpected == 0, "R8 short re-wake",
          {fsyncEn, unexpected}, 2'b10);

    // sleep with two failed polls then success
    expectBus(1, 8'd2, V_SLP, 0, "R9");
    expectBus(0, 8'd119, 8'h00, SLEEP_C, "R9");
    expectBus(0, 8'd119, 8'h7F, 2, "R9");
    expectBus(0, 8'd119, 8'h80, 2, "R9");
    pulse(1);
    waitMode(3'd2, 400, "R9", c);
    check(!seqError && !fsyncEn && expQ.size() == 0, "R9 retries then sleep",
          {seqError, fsyncEn}, 0);

    // sleep command during wake is held (R13)
    rises = clkRises;
    expectBus(1, 8'd2, V_WAKE, 0, "R13");
    expectBus(1, 8'd2, V_SLP, WAKE_C, "R13");
    expectBus(0, 8'd119, 8'h80, SLEEP_C, "R13");
    pulse(0);
    waitMode(3'd3, 10, "R13", c);
    repeat (3) @(negedge clk);
    pulse(1);
    waitMode(3'd2, 400, "R13", c);
    check(clkRises == rises + 1 && !fsyncEn && expQ.size() == 0,
          "R13 held sleep ran after active", clkRises - rises, 1);

    // exhausted polls (R10)
    expectBus(1, 8'd2, V_WAKE, 0, "R10");
    pulse(0);
    waitMode(3'd4, 200, "R10", c);
    expectBus(1, 8'd2, V_SLP, 0, "R10");
    for (int i = 0; i <= RETRIES; i++) expectBus(0, 8'd119, 8'h00, (i == 0) ? SLEEP_C : 2, "R10");
    pulse(1);
    c = 0;
    while (!seqError && c < 400) begin @(negedge clk); c++; end
    check(seqError && mode == 3'd5 && fsyncEn, "R10 error flagged",
          {seqError, mode, fsyncEn}, {1'b1, 3'd5, 1'b1});
    repeat (20) @(negedge clk);
    check(expQ.size() == 0 && unexpected == 0 && mode == 3'd5, "R10 stalled, no requests",
          expQ.size(), 0);

    // shutdown from stalled state (R12)
    @(negedge clk);
    cmdShutdown = 1'b1;
    suppliesOk  = 1'b0;
    @(negedge clk);
    cmdShutdown = 1'b0;
    check(!pwrDownN && !fsyncEn && !bclkEn && !seqError && !busReq && mode == 3'd0,
          "R12 shutdown next cycle", {pwrDownN, fsyncEn, seqError, mode}, 0);
    repeat (10) @(negedge clk);
    check(!pwrDownN, "R12 stays off", pwrDownN, 0);
    suppliesOk = 1'b1;
    waitMode(3'd2, 100, "R12", c);
    expectBus(1, 8'd2, V_WAKE, 0, "R12");
    expectBus(1, 8'd115, V_IN, WAKE_C, "R12");
    expectBus(1, 8'd116, V_OUT, 0, "R12");
    expectBus(1, 8'd117, V_PWR, 0, "R12");
    pulse(0);
    waitMode(3'd4, 200, "R12", c);
    check(expQ.size() == 0 && fsyncEn, "R12 full config replayed", expQ.size(), 0);

    repeat (10) @(negedge clk);
    check(unexpected == 0 && clkEarly == 0, "R5 no stray requests or early clocks",
          unexpected + clkEarly, 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule